// File: doc/BRIEF.md
# Eight-Port Serial Management Target

This block is the management-register target of a device that holds eight network ports behind one shared two-wire management bus. The station manager drives the management clock and a bidirectional data line. The block samples that line on each rising clock edge and recognises standard clause-22 frames. A frame is a preamble, start bits, an opcode, a 5-bit PHY address, a 5-bit register number, a turnaround and 16 data bits. The block answers every frame whose PHY address is one of the eight port addresses. Port `n` uses address `base + n`, where the 5-bit base comes from strap inputs.

Each port owns a small bank of 16-bit registers. Register 0 of every port is also presented in parallel on `cfg_out`; bit 5 of that register selects fibre operation for the port. While the management-disable input is high, the serial path neither reads nor writes. Register 0 of every port then follows the parallel hardware-configuration inputs. While the input is low, those inputs are ignored and serial writes own the registers.

Top module: `mdio_multiport_slave`

## Requirements
- R1: A frame is accepted only after at least PRE_LEN (32) consecutive ones on the data line. It then needs start bits 0,1, opcode 1,0 (read) or 0,1 (write), the PHY address and register number (5 bits each, MSB first), two turnaround bits and 16 data bits (MSB first). All bits are sampled on the rising edge of `mdc`; a longer preamble is also accepted.
- R2: Port n (0..7) answers the PHY address (base_addr + n) mod 32. A frame for any other address writes nothing and never drives the line (`mdio_oe` stays 0).
- R3: On an accepted read, `mdio_oe` stays low during the first turnaround bit. The block drives 0 during the second turnaround bit, then the 16 register bits MSB first, each updated just after a rising edge. It releases the line right after the last data bit, so `mdio_oe` is high for exactly 17 bit times.
- R4: Each port holds registers 0..NREG-1 (NREG = 4), each 16 bits and cleared by reset. A write to one port or register leaves every other register unchanged.
- R5: A read of a register number at or above NREG returns 0x0000. A write to such a register number changes nothing.
- R6: A write takes effect only once all 16 data bits have been sampled. A frame cut short by raising `mgmt_dis` before its last data bit changes no register.
- R7: A frame whose start bits are not 0,1, whose opcode is 0,0 or 1,1, or whose preamble holds fewer than 32 ones is ignored and changes no register.
- R8: While `mgmt_dis` is high, the block never drives the data line (`mdio_oe` low from the next edge on) and serial writes change no register.
- R9: While `mgmt_dis` is high, register 0 of port n takes `hw_cfg[16n+15:16n]` on every rising edge. While it is low, changes on `hw_cfg` have no effect.
- R10: `cfg_out[16n+15:16n]` equals register 0 of port n. Bit 5 of it is the fibre-select bit, settable by a serial write to register 0 or by `hw_cfg`. `cfg_out` changes only through a serial write or a hardware load.
- R11: `rst_n` low clears every register and keeps `mdio_oe` low. Its release is synchronised to `mdc` and takes effect two edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock from the station manager |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_dis | input | 1 | High: serial access off, hardware configuration in force |
| base_addr | input | 5 | Strapped base PHY address |
| hw_cfg | input | NPORT*16 | Parallel register-0 values, port n at bits 16n+15:16n |
| mdio_i | input | 1 | Sampled level of the shared data line |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Output enable of the data-line driver |
| cfg_out | output | NPORT*16 | Register 0 of every port, port n at bits 16n+15:16n |

## Verification
A corrupted parser state or bit counter shows up in the same frame. The turnaround zero moves, `mdio_oe` stays high for a number of bit times other than 17, or the read data comes back shifted by a bit. A wrong port decode or a write committed too early becomes visible at the next read-back of the affected register, or on `cfg_out` one edge after the write. A hardware-load path that stays active while enabled shows on `cfg_out` one edge after `hw_cfg` changes.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;
  localparam int REG_W  = 16;
  localparam int PHY_W  = 5;
  localparam int REGA_W = 5;
  localparam int ADDR_W = PHY_W + REGA_W;

  typedef enum logic [2:0] {
    S_PRE,
    S_START,
    S_OP,
    S_ADDR,
    S_TA,
    S_DATA
  } fsm_e;
endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_slv_pkg::*;
#(
  parameter int NPORT   = 8,
  parameter int PRE_LEN = 32,
  localparam int PW     = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int PCW    = $clog2(PRE_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dis,
  input  logic              mdi,
  input  logic [PHY_W-1:0]  base,
  input  logic [REG_W-1:0]  rd_data,
  output logic [PW-1:0]     sel_port,
  output logic [REGA_W-1:0] sel_reg,
  output logic              wr_en,
  output logic [REG_W-1:0]  wr_data,
  output logic              mdo,
  output logic              mdo_oe
);

  fsm_e              state_q, state_d;
  logic [4:0]        cnt_q, cnt_d;
  logic [PCW-1:0]    pre_q, pre_d;
  logic              rd_q, rd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [REG_W-1:0]  dsh_q, dsh_d;
  logic              mdo_q, mdo_d;
  logic              oe_q, oe_d;
  logic              wr_q, wr_d;

  logic [ADDR_W-1:0] addr_next;
  logic [PHY_W-1:0]  diff_next;
  logic [PHY_W-1:0]  diff_cur;
  logic              hit_next;

  // address match on the word as it completes this edge
  assign addr_next = {addr_q[ADDR_W-2:0], mdi};
  assign diff_next = addr_next[ADDR_W-1 -: PHY_W] - base;
  assign hit_next  = (int'(diff_next) < NPORT);
  assign diff_cur  = addr_q[ADDR_W-1 -: PHY_W] - base;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pre_d   = pre_q;
    rd_d    = rd_q;
    addr_d  = addr_q;
    dsh_d   = dsh_q;
    mdo_d   = mdo_q;
    oe_d    = oe_q;
    wr_d    = 1'b0;
    if (dis) begin
      state_d = S_PRE;
      pre_d   = '0;
      oe_d    = 1'b0;
      mdo_d   = 1'b0;
    end else begin
      unique case (state_q)
        S_PRE: begin
          if (mdi) begin
            if (pre_q != PCW'(PRE_LEN)) pre_d = pre_q + 1'b1;
          end else begin
            if (pre_q == PCW'(PRE_LEN)) state_d = S_START;
            pre_d = '0;
          end
        end
        S_START: begin
          cnt_d   = '0;
          state_d = mdi ? S_OP : S_PRE;
        end
        S_OP: begin
          if (cnt_q == 5'd0) begin
            rd_d  = mdi;
            cnt_d = 5'd1;
          end else begin
            cnt_d = '0;
            if (rd_q != mdi) state_d = S_ADDR;
            else             state_d = S_PRE;
          end
        end
        S_ADDR: begin
          addr_d = addr_next;
          if (cnt_q == 5'(ADDR_W - 1)) begin
            cnt_d   = '0;
            state_d = hit_next ? S_TA : S_PRE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_TA: begin
          if (cnt_q == 5'd0) begin
            cnt_d = 5'd1;
            if (rd_q) begin
              dsh_d = rd_data;
              oe_d  = 1'b1;
              mdo_d = 1'b0;
            end
          end else begin
            cnt_d   = '0;
            state_d = S_DATA;
            if (rd_q) begin
              mdo_d = dsh_q[REG_W-1];
              dsh_d = {dsh_q[REG_W-2:0], 1'b0};
            end
          end
        end
        S_DATA: begin
          cnt_d = cnt_q + 1'b1;
          if (rd_q) begin
            if (cnt_q == 5'(REG_W - 1)) begin
              oe_d    = 1'b0;
              mdo_d   = 1'b0;
              state_d = S_PRE;
            end else begin
              mdo_d = dsh_q[REG_W-1];
              dsh_d = {dsh_q[REG_W-2:0], 1'b0};
            end
          end else begin
            dsh_d = {dsh_q[REG_W-2:0], mdi};
            if (cnt_q == 5'(REG_W - 1)) begin
              wr_d    = 1'b1;
              state_d = S_PRE;
            end
          end
        end
        default: state_d = S_PRE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_PRE;
      cnt_q   <= '0;
      pre_q   <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      dsh_q   <= '0;
      mdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pre_q   <= pre_d;
      rd_q    <= rd_d;
      addr_q  <= addr_d;
      dsh_q   <= dsh_d;
      mdo_q   <= mdo_d;
      oe_q    <= oe_d;
      wr_q    <= wr_d;
    end
  end

  assign sel_port = diff_cur[PW-1:0];
  assign sel_reg  = addr_q[REGA_W-1:0];
  assign wr_en    = wr_q;
  assign wr_data  = dsh_q;
  assign mdo      = mdo_q;
  assign mdo_oe   = oe_q;

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_slv_pkg::*;
#(
  parameter int NREG = 4,
  localparam int RIW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REGA_W-1:0] wr_reg,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              hw_load,
  input  logic [REG_W-1:0]  hw_val,
  input  logic [REGA_W-1:0] rd_reg,
  output logic [REG_W-1:0]  rd_data,
  output logic [REG_W-1:0]  reg0
);

  logic [NREG-1:0][REG_W-1:0] regs_q, regs_d;

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      regs_d[r] = regs_q[r];
      if (r == 0 && hw_load) begin
        regs_d[r] = hw_val;
      end else if (wr_en && int'(wr_reg) == r) begin
        regs_d[r] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      regs_q <= regs_d;
    end
  end

  assign rd_data = (int'(rd_reg) < NREG) ? regs_q[rd_reg[RIW-1:0]] : '0;
  assign reg0    = regs_q[0];

endmodule

// File: rtl/mdio_multiport_slave.sv
module mdio_multiport_slave
  import mdio_slv_pkg::*;
#(
  parameter int NPORT   = 8,
  parameter int NREG    = 4,
  parameter int PRE_LEN = 32,
  localparam int PW     = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                   mdc,
  input  logic                   rst_n,
  input  logic                   mgmt_dis,
  input  logic [PHY_W-1:0]       base_addr,
  input  logic [NPORT*REG_W-1:0] hw_cfg,
  input  logic                   mdio_i,
  output logic                   mdio_o,
  output logic                   mdio_oe,
  output logic [NPORT*REG_W-1:0] cfg_out
);

  logic [1:0]                  rsync_q;
  logic                        rst_sync_n;
  logic [PW-1:0]               sel_port;
  logic [REGA_W-1:0]           sel_reg;
  logic                        fsm_wr;
  logic [REG_W-1:0]            fsm_wdata;
  logic [REG_W-1:0]            rd_data;
  logic [NPORT-1:0][REG_W-1:0] bank_rd;

  // reset asserts at once, releases on the second mdc edge
  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  mdio_frame_fsm #(
    .NPORT  (NPORT),
    .PRE_LEN(PRE_LEN)
  ) u_fsm (
    .clk     (mdc),
    .rst_n   (rst_sync_n),
    .dis     (mgmt_dis),
    .mdi     (mdio_i),
    .base    (base_addr),
    .rd_data (rd_data),
    .sel_port(sel_port),
    .sel_reg (sel_reg),
    .wr_en   (fsm_wr),
    .wr_data (fsm_wdata),
    .mdo     (mdio_o),
    .mdo_oe  (mdio_oe)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mdio_reg_bank #(
      .NREG(NREG)
    ) u_bank (
      .clk    (mdc),
      .rst_n  (rst_sync_n),
      .wr_en  (fsm_wr && (sel_port == PW'(p))),
      .wr_reg (sel_reg),
      .wr_data(fsm_wdata),
      .hw_load(mgmt_dis),
      .hw_val (hw_cfg[p*REG_W +: REG_W]),
      .rd_reg (sel_reg),
      .rd_data(bank_rd[p]),
      .reg0   (cfg_out[p*REG_W +: REG_W])
    );
  end

  assign rd_data = bank_rd[sel_port];

endmodule

// File: rtl/mdio_slv_chk.sv
module mdio_slv_chk #(
  parameter int NPORT = 8
) (
  input logic                mdc,
  input logic                rst_n,
  input logic                mgmt_dis,
  input logic                mdio_o,
  input logic                mdio_oe,
  input logic                wr_commit,
  input logic [NPORT*16-1:0] hw_cfg,
  input logic [NPORT*16-1:0] cfg_out
);

  logic [4:0] oe_run;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n)           oe_run <= '0;
    else if (!mdio_oe)    oe_run <= '0;
    else if (oe_run != 5'd31) oe_run <= oe_run + 1'b1;
  end

  p_no_drive_dis_r8: assert property (@(posedge mdc) disable iff (!rst_n)
    mgmt_dis |=> !mdio_oe);

  p_ta_zero_r3: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  p_oe_max_r3: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (oe_run < 5'd17));

  p_oe_len_r3: assert property (@(posedge mdc) disable iff (!rst_n)
    ($fell(mdio_oe) && !$past(mgmt_dis)) |-> (oe_run == 5'd17));

  p_hw_follow_r9: assert property (@(posedge mdc) disable iff (!rst_n)
    mgmt_dis |=> (cfg_out == $past(hw_cfg)));

  p_cfg_hold_r10: assert property (@(posedge mdc) disable iff (!rst_n)
    (!mgmt_dis && !wr_commit) |=> $stable(cfg_out));

endmodule

bind mdio_multiport_slave mdio_slv_chk #(.NPORT(NPORT)) u_chk (
  .mdc      (mdc),
  .rst_n    (rst_sync_n),
  .mgmt_dis (mgmt_dis),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .wr_commit(fsm_wr),
  .hw_cfg   (hw_cfg),
  .cfg_out  (cfg_out)
);

// File: tb/test_mdio_multiport_slave.sv
module test_mdio_multiport_slave;

  localparam int NPORT = 8;
  localparam logic [4:0] BASE = 5'd28;

  logic                mdc;
  logic                rst_n;
  logic                mgmt_dis;
  logic [NPORT*16-1:0] hw_cfg;
  logic                mdio_o, mdio_oe;
  logic [NPORT*16-1:0] cfg_out;
  logic                m_oe, m_val;
  logic                line;
  int                  checks, errors, cyc;
  bit                  done;

  assign line = mdio_oe ? mdio_o : (m_oe ? m_val : 1'b1);

  mdio_multiport_slave i_mdio_multiport_slave (
    .mdc      (mdc),
    .rst_n    (rst_n),
    .mgmt_dis (mgmt_dis),
    .base_addr(BASE),
    .hw_cfg   (hw_cfg),
    .mdio_i   (line),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .cfg_out  (cfg_out)
  );

  initial mdc = 1'b0;
  always #5 mdc = ~mdc;

  always @(posedge mdc) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // drives one frame; the slave is observed just after each falling edge
  task automatic send_frame(input int pre_len, input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd,
                            input int stop_at, output logic [15:0] rd, output logic drove,
                            output logic shape_ok);
    logic [31:0] tail;
    bit          is_rd;
    int          ta;
    tail     = {st, op, phy, rg, 2'b10, wd};
    is_rd    = (op == 2'b10) && (st == 2'b01);
    ta       = pre_len + 14;
    rd       = '0;
    drove    = 1'b0;
    shape_ok = 1'b1;
    for (int i = 0; i < pre_len + 32; i++) begin
      @(negedge mdc);
      if (i == stop_at) mgmt_dis = 1'b1;
      if (is_rd && i >= ta) m_oe = 1'b0;
      else begin
        m_oe  = 1'b1;
        m_val = (i < pre_len) ? 1'b1 : tail[31 - (i - pre_len)];
      end
      #1;
      if (mdio_oe) drove = 1'b1;
      if (is_rd && i == ta && mdio_oe) shape_ok = 1'b0;
      if (is_rd && i == ta + 1 && !(mdio_oe && !mdio_o)) shape_ok = 1'b0;
      if (is_rd && i > ta + 1) begin
        if (!mdio_oe) shape_ok = 1'b0;
        rd = {rd[14:0], mdio_o};
      end
    end
    @(negedge mdc);
    #1;
    if (mdio_oe) begin
      shape_ok = 1'b0;
      drove    = 1'b1;
    end
    m_oe  = 1'b1;
    m_val = 1'b0;
    if (stop_at >= 0) mgmt_dis = 1'b0;
    repeat (2) @(negedge mdc);
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] exp,
                         input string req);
    logic [15:0] rd;
    logic        dr, sh;
    send_frame(32, 2'b01, 2'b10, phy, rg, 16'h0, -1, rd, dr, sh);
    chk(dr && sh && rd == exp, req, {15'b0, dr, rd}, {16'h1, exp});
  endtask

  task automatic do_write(input int pre_len, input logic [1:0] st, input logic [1:0] op,
                          input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    logic [15:0] rd;
    logic        dr, sh;
    send_frame(pre_len, st, op, phy, rg, wd, -1, rd, dr, sh);
    chk(!dr, "R2 slave silent on write", {31'b0, dr}, 32'h0);
  endtask

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic [15:0] ex;
    logic        drv;
  } vec_t;

  // base 28: ports 0..3 at 28..31, ports 4..7 at 0..3 (R2 wrap)
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd28, 5'd1, 16'hA5A5, 16'h0000, 1'b0},
    '{1'b1, 5'd28, 5'd1, 16'h0000, 16'hA5A5, 1'b1},
    '{1'b0, 5'd3,  5'd2, 16'h1234, 16'h0000, 1'b0},
    '{1'b1, 5'd3,  5'd2, 16'h0000, 16'h1234, 1'b1},
    '{1'b1, 5'd28, 5'd2, 16'h0000, 16'h0000, 1'b1},  // R4 isolation
    '{1'b1, 5'd4,  5'd1, 16'h0000, 16'h0000, 1'b0},  // R2 above range
    '{1'b0, 5'd4,  5'd1, 16'hFFFF, 16'h0000, 1'b0},
    '{1'b1, 5'd28, 5'd1, 16'h0000, 16'hA5A5, 1'b1},
    '{1'b1, 5'd27, 5'd1, 16'h0000, 16'h0000, 1'b0},  // R2 below base
    '{1'b1, 5'd29, 5'd7, 16'h0000, 16'h0000, 1'b1},  // R5
    '{1'b0, 5'd29, 5'd7, 16'hBEEF, 16'h0000, 1'b0},
    '{1'b1, 5'd29, 5'd7, 16'h0000, 16'h0000, 1'b1},  // R5 write discarded
    '{1'b0, 5'd31, 5'd0, 16'h0020, 16'h0000, 1'b0},  // R10 fibre bit
    '{1'b1, 5'd31, 5'd0, 16'h0000, 16'h0020, 1'b1},
    '{1'b0, 5'd0,  5'd3, 16'hC3C3, 16'h0000, 1'b0},
    '{1'b1, 5'd0,  5'd3, 16'h0000, 16'hC3C3, 1'b1}
  };

  logic [NPORT*16-1:0] pat;

  initial begin
    logic [15:0] rd;
    logic        dr, sh;
    checks   = 0;
    errors   = 0;
    cyc      = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    mgmt_dis = 1'b0;
    hw_cfg   = '0;
    m_oe     = 1'b1;
    m_val    = 1'b0;
    repeat (3) @(negedge mdc);
    chk(!mdio_oe, "R11 oe in reset", {31'b0, mdio_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge mdc);
    chk(!mdio_oe && cfg_out == '0, "R11 reset state", cfg_out[31:0], 32'h0);

    for (int v = 0; v < NV; v++) begin
      send_frame(32, 2'b01, VECS[v].rd ? 2'b10 : 2'b01, VECS[v].phy, VECS[v].rg,
                 VECS[v].wd, -1, rd, dr, sh);
      if (VECS[v].drv)
        chk(dr && sh && rd == VECS[v].ex, "R1 R3 R4 vector read",
            {v[7:0], 7'b0, sh, rd}, {v[7:0], 8'h1, VECS[v].ex});
      else
        chk(!dr, "R2 vector no drive", {v[7:0], 23'b0, dr}, {v[7:0], 24'h0});
    end

    // R10: register 0 of port 3 visible on the parallel output
    chk(cfg_out[3*16 +: 16] == 16'h0020 && cfg_out[15:0] == 16'h0,
        "R10 cfg_out", {cfg_out[63:48], cfg_out[15:0]}, 32'h0020_0000);

    // R1: longer preamble still accepted
    do_write(40, 2'b01, 2'b01, 5'd30, 5'd3, 16'h6D6D);
    do_read(5'd30, 5'd3, 16'h6D6D, "R1 long preamble");

    // R7: bad opcode, bad start, short preamble
    do_write(32, 2'b01, 2'b11, 5'd28, 5'd1, 16'h5A5A);
    do_read(5'd28, 5'd1, 16'hA5A5, "R7 bad opcode");
    do_write(32, 2'b00, 2'b01, 5'd28, 5'd1, 16'h5A5A);
    do_read(5'd28, 5'd1, 16'hA5A5, "R7 bad start");
    do_write(31, 2'b01, 2'b01, 5'd28, 5'd1, 16'h5A5A);
    do_read(5'd28, 5'd1, 16'hA5A5, "R7 short preamble");

    // R6: disable raised in the middle of the data bits
    send_frame(32, 2'b01, 2'b01, 5'd28, 5'd1, 16'h0F0F, 32 + 24, rd, dr, sh);
    do_read(5'd28, 5'd1, 16'hA5A5, "R6 aborted write");

    // R9: hardware load while disabled
    for (int p = 0; p < NPORT; p++) pat[p*16 +: 16] = 16'(p * 16'h0101) ^ 16'h0020;
    mgmt_dis = 1'b1;
    hw_cfg   = pat;
    repeat (2) @(negedge mdc);
    chk(cfg_out == pat, "R9 hw load", cfg_out[31:0], pat[31:0]);

    // R8: no serial access while disabled
    send_frame(32, 2'b01, 2'b10, 5'd28, 5'd1, 16'h0, -1, rd, dr, sh);
    chk(!dr, "R8 read blocked", {31'b0, dr}, 32'h0);
    send_frame(32, 2'b01, 2'b01, 5'd28, 5'd2, 16'h7777, -1, rd, dr, sh);
    chk(!dr, "R8 write silent", {31'b0, dr}, 32'h0);
    mgmt_dis = 1'b0;
    repeat (2) @(negedge mdc);
    do_read(5'd28, 5'd2, 16'h0000, "R8 write blocked");
    do_read(5'd28, 5'd0, pat[15:0], "R9 hw value readable");

    // R9: hw_cfg ignored while enabled
    hw_cfg = ~pat;
    repeat (3) @(negedge mdc);
    chk(cfg_out == pat, "R9 hw ignored", cfg_out[31:0], pat[31:0]);

    // R10: serial write to register 0 clears fibre bit of port 1
    do_write(32, 2'b01, 2'b01, 5'd29, 5'd0, 16'h0000);
    chk(cfg_out[16 +: 16] == 16'h0000 && cfg_out[0 +: 16] == pat[15:0],
        "R10 write reg0", {cfg_out[31:16], cfg_out[15:0]}, {16'h0, pat[15:0]});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule